// File: doc/BRIEF.md
# Debug Request Mailbox

This block lets software on a simple single-cycle register bus drive a debug request/response channel pair that uses valid/ready handshakes. Software loads a target address word and a data word into two registers. It then writes an operation code, and that write is the trigger that launches one request on the request channel. The request carries a snapshot of the address and data registers taken at that moment.

When the far side answers, the response data and result code are captured into sticky registers. Software polls a status word to see when the answer has arrived, reads the captured values, and then writes the status word to acknowledge. After the acknowledge the mailbox accepts a new operation.

Only one transaction is outstanding at a time. The response channel is back-pressured while an unacknowledged answer is held, so an unread answer is never overwritten.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset the status word (offset 0x14) reads 0x1, `req_valid` is 0, `rsp_ready` is 1, and the address, data and opcode registers read 0.
- R2: The request address (0x31000), request data (0x31004) and opcode (0x31008, low 2 bits, upper bits read 0) registers read back their last accepted written value. Any address outside the six mapped words reads 0.
- R3: A write to 0x31008 while status bit 0 is 1 raises `req_valid` in the next cycle. At that point `req_op` equals the low 2 bits of the written word and `req_addr`/`req_data` equal the address and data registers. These outputs hold steady until the cycle after `req_valid && req_ready`, when `req_valid` falls.
- R4: Status bit 0 reads 0 from the cycle after a launching opcode write until the cycle after the response is acknowledged. A status write made before any response has arrived leaves it at 0.
- R5: A write to 0x31008 while status bit 0 is 0 is ignored: no new request is issued and the opcode register keeps its value.
- R6: On `rsp_valid && rsp_ready` the response data (read at 0x3100c) and result code (read at 0x31010, low 2 bits) are captured and status bit 1 becomes 1. While bit 1 is 1, `rsp_ready` is 0 and the captured values do not change.
- R7: Any write to the status word (0x31014) clears status bit 1 and raises `rsp_ready` again. If a response was held, status bit 0 returns to 1.
- R8: Writes to the response data and result code offsets have no effect on their read values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW (20) | Register bus address |
| bus_we | input | 1 | Register bus write strobe |
| bus_wdata | input | DW (32) | Register bus write data |
| bus_rdata | output | DW (32) | Register bus read data, combinational on bus_addr |
| req_valid | output | 1 | Request channel valid |
| req_ready | input | 1 | Request channel ready |
| req_addr | output | DW (32) | Request target address |
| req_data | output | DW (32) | Request write data |
| req_op | output | OPW (2) | Request operation code |
| rsp_valid | input | 1 | Response channel valid |
| rsp_ready | output | 1 | Response channel ready |
| rsp_data | input | DW (32) | Response data |
| rsp_code | input | OPW (2) | Response result code |

## Verification
The hardest situations to reach are those where two events meet. One is a second response offered while an earlier one is still unacknowledged. The other is an opcode write arriving while a transaction is still in flight, either before the request handshake or after the answer has been captured. The bench's responder drives both cases on purpose: it holds `req_ready` low for a random number of cycles and offers a second `rsp_valid` with different data after the first capture. Random transactions also interleave early status writes, opcode retriggers and writes to the read-only offsets at these points.

// File: rtl/dbg_mailbox.sv
module dbg_mailbox #(
  parameter int AW = 20,
  parameter int DW = 32,
  parameter int OPW = 2,
  parameter logic [AW-1:0] BASE = 20'h31000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_we,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           req_valid,
  input  logic           req_ready,
  output logic [DW-1:0]  req_addr,
  output logic [DW-1:0]  req_data,
  output logic [OPW-1:0] req_op,
  input  logic           rsp_valid,
  output logic           rsp_ready,
  input  logic [DW-1:0]  rsp_data,
  input  logic [OPW-1:0] rsp_code
);
  localparam logic [AW-1:0] A_ADDR = BASE;
  localparam logic [AW-1:0] A_DATA = BASE + AW'(4);
  localparam logic [AW-1:0] A_OP   = BASE + AW'(8);
  localparam logic [AW-1:0] A_RDAT = BASE + AW'(12);
  localparam logic [AW-1:0] A_RCOD = BASE + AW'(16);
  localparam logic [AW-1:0] A_STAT = BASE + AW'(20);

  logic [DW-1:0]  addr_q, data_q, rdat_q;
  logic [OPW-1:0] op_q, rcod_q;
  logic           inflight, rsp_pend;

  wire wr_addr = bus_we && (bus_addr == A_ADDR);
  wire wr_data = bus_we && (bus_addr == A_DATA);
  wire wr_op   = bus_we && (bus_addr == A_OP);
  wire wr_stat = bus_we && (bus_addr == A_STAT);
  wire launch  = wr_op && !inflight;
  wire capture = rsp_valid && rsp_ready;
  wire ack     = wr_stat && rsp_pend;

  assign rsp_ready = !rsp_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q    <= '0;
      data_q    <= '0;
      op_q      <= '0;
      rdat_q    <= '0;
      rcod_q    <= '0;
      req_addr  <= '0;
      req_data  <= '0;
      req_op    <= '0;
      req_valid <= 1'b0;
      inflight  <= 1'b0;
      rsp_pend  <= 1'b0;
    end else begin
      if (wr_addr) addr_q <= bus_wdata;
      if (wr_data) data_q <= bus_wdata;
      if (launch) begin
        op_q      <= bus_wdata[OPW-1:0];
        req_op    <= bus_wdata[OPW-1:0];
        req_addr  <= addr_q;
        req_data  <= data_q;
        req_valid <= 1'b1;
        inflight  <= 1'b1;
      end else if (req_valid && req_ready) begin
        req_valid <= 1'b0;
      end
      if (capture) begin
        rdat_q   <= rsp_data;
        rcod_q   <= rsp_code;
        rsp_pend <= 1'b1;
      end else if (ack) begin
        rsp_pend <= 1'b0;
        inflight <= 1'b0;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_ADDR:  bus_rdata = addr_q;
      A_DATA:  bus_rdata = data_q;
      A_OP:    bus_rdata = DW'(op_q);
      A_RDAT:  bus_rdata = rdat_q;
      A_RCOD:  bus_rdata = DW'(rcod_q);
      A_STAT:  bus_rdata = DW'({rsp_pend, !inflight});
      default: bus_rdata = '0;
    endcase
  end

  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_data) && $stable(req_op));
  a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> req_valid && inflight);
  a_r5_busy_op_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_op && inflight |=> $stable(op_q));
  a_r6_rsp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_pend && !wr_stat |=> rsp_pend && $stable(rdat_q) && $stable(rcod_q));
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !rsp_pend && !inflight && rsp_ready);
endmodule

// File: tb/dbg_mailbox_test.sv
module dbg_mailbox_test;
  localparam int CLK_P = 10;
  localparam logic [19:0] B = 20'h31000;

  logic clk = 0, rst_n = 0;
  logic [19:0] bus_addr = '0;
  logic bus_we = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic req_valid, req_ready = 0, rsp_valid = 0, rsp_ready;
  logic [31:0] req_addr, req_data, rsp_data = '0;
  logic [1:0] req_op, rsp_code = '0;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] e_addr = 0, e_data = 0, e_rdat = 0;
  logic [1:0] e_op = 0, e_rcod = 0;

  dbg_mailbox uut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] status_exp(input bit busy, input bit pend);
    return {30'b0, pend, !busy};
  endfunction

  task automatic wr(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [19:0] a, output logic [31:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic chk_rd(input string tag, input logic [19:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic txn(input logic [31:0] a, input logic [31:0] d, input logic [1:0] op,
                     input logic [31:0] rd_v, input logic [1:0] rc, input int delay,
                     input bit poke_busy, input bit early_ack, input bit second_rsp);
    wr(B, a); e_addr = a;
    wr(B + 4, d); e_data = d;
    wr(B + 8, {$urandom(), op}); e_op = op;
    check("R3 req_valid", 32'(req_valid), 1);
    check("R3 req_addr", req_addr, e_addr);
    check("R3 req_data", req_data, e_data);
    check("R3 req_op", 32'(req_op), 32'(e_op));
    chk_rd("R4 busy status", B + 20, status_exp(1, 0));
    chk_rd("R2 op readback", B + 8, 32'(e_op));
    if (poke_busy) begin
      wr(B + 8, 32'(~op));
      chk_rd("R5 op kept", B + 8, 32'(e_op));
    end
    repeat (delay) @(negedge clk);
    check("R3 held", 32'(req_valid), 1);
    check("R3 addr held", req_addr, e_addr);
    req_ready = 1;
    @(negedge clk);
    req_ready = 0;
    check("R3 valid drop", 32'(req_valid), 0);
    if (poke_busy) begin
      wr(B + 8, 32'(op ^ 2'd1));
      check("R5 no new req", 32'(req_valid), 0);
      chk_rd("R5 op kept2", B + 8, 32'(e_op));
    end
    if (early_ack) begin
      wr(B + 20, 32'hFFFF_FFFF);
      chk_rd("R4 early ack no effect", B + 20, status_exp(1, 0));
    end
    check("R6 ready before", 32'(rsp_ready), 1);
    rsp_valid = 1; rsp_data = rd_v; rsp_code = rc;
    @(negedge clk);
    rsp_valid = 0;
    e_rdat = rd_v; e_rcod = rc;
    chk_rd("R6 status pend", B + 20, status_exp(1, 1));
    check("R6 ready low", 32'(rsp_ready), 0);
    if (second_rsp) begin
      rsp_valid = 1; rsp_data = ~rd_v; rsp_code = ~rc;
      @(negedge clk);
      rsp_valid = 0;
    end
    chk_rd("R6 rsp data", B + 12, e_rdat);
    chk_rd("R6 rsp code", B + 16, 32'(e_rcod));
    if (poke_busy) begin
      wr(B + 8, 32'(op));
      check("R5 no req when pend", 32'(req_valid), 0);
    end
    wr(B + 12, ~rd_v);
    wr(B + 16, 32'(~rc));
    chk_rd("R8 rsp data ro", B + 12, e_rdat);
    chk_rd("R8 rsp code ro", B + 16, 32'(e_rcod));
    wr(B + 20, $urandom());
    chk_rd("R7 ack status", B + 20, status_exp(0, 0));
    check("R7 ready back", 32'(rsp_ready), 1);
    chk_rd("R2 addr readback", B, e_addr);
    chk_rd("R2 data readback", B + 4, e_data);
  endtask

  task automatic finish_up;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk_rd("R1 status", B + 20, 32'h1);
    check("R1 req_valid", 32'(req_valid), 0);
    check("R1 rsp_ready", 32'(rsp_ready), 1);
    chk_rd("R1 addr", B, 0);
    chk_rd("R1 data", B + 4, 0);
    chk_rd("R1 op", B + 8, 0);
    chk_rd("R2 unmapped hi", B + 24, 0);
    chk_rd("R2 unmapped lo", B - 4, 0);
    wr(B + 24, 32'hDEAD_BEEF);
    chk_rd("R2 unmapped write", B + 24, 0);
    txn(32'h10, 32'h1, 2'd2, 32'h0, 2'd0, 0, 0, 0, 0);
    txn(32'h11, 32'h0, 2'd1, 32'h0000_0F03, 2'd0, 3, 1, 1, 1);
    txn(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd3, 32'hFFFF_FFFF, 2'd3, 1, 1, 0, 1);
    for (int i = 0; i < 40; i++)
      txn($urandom(), $urandom(), 2'($urandom()), $urandom(), 2'($urandom()),
          int'($urandom_range(0, 5)), bit'($urandom()), bit'($urandom()), bit'($urandom()));
    done = 1;
    finish_up();
  end
endmodule